// File: doc/BRIEF.md
# Bus Inter-Word Gap Watchdog

This block guards the packetized recording path of a dual-redundant serial data bus monitor. While a recording packet is open it measures how long the bus has been silent since the last valid word was seen on either bus. When that silence reaches a host-programmed limit it issues a one-cycle finalize pulse, so that the storage logic can close the packet. It can also raise two sticky interrupt flags: one saying that a packet is ready, and one saying that the gap limit expired.

The limit is a 16-bit count N of 10 µs units. Time comes from a 1 µs strobe, which a prescaler divides into 10 µs units. The valid-word pulses arrive about 3 µs after the end of each word, so a short trailing count adds 3 µs after the N units. Finalization therefore happens 10N+3 µs after the last word. A word that began too late to be validated before that point does not hold the packet open. A limit of zero turns gap-based finalization off. The timer works only in packetized recording mode.

Top module: `bus_gap_watchdog`

## Requirements
- R1: With `gap_limit` = N > 0 and no further word, `finalize` is high for exactly one clock cycle. It rises on the cycle after the clock edge that samples the (10N+3)-th `tick_1us` strobe counted after the last word pulse, and it does not rise earlier.
- R2: A pulse on `word_a` or on `word_b` restarts the measurement from zero. This holds for every valid word, including words from incomplete messages.
- R3: While `gap_limit` is 0, `finalize` never rises.
- R4: While `mode_pkt` is 0, the timer stays idle and `finalize` never rises.
- R5: While `pkt_open` is 0, no finalize is issued, and a running measurement is dropped.
- R6: After a finalize, the timer stays idle and produces no further pulse until the next word pulse.
- R7: On each finalize, `irq_ready` is set if `ien_ready` is 1, and `irq_gap` is set if `ien_gap` is 1. A flag whose enable is 0 is left unchanged. Set flags remain set.
- R8: A one-cycle pulse on `clr_ready` or `clr_gap` clears the matching flag. If a set and a clear land in the same cycle, the set wins.
- R9: A word pulse in the same cycle as the final (10N+3)-th strobe restarts the timer and suppresses that finalize.
- R10: After reset, `finalize`, `irq_ready` and `irq_gap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pkt | input | 1 | 1 = packetized recording mode |
| tick_1us | input | 1 | One-cycle strobe every 1 µs |
| word_a | input | 1 | Valid word completed on bus A |
| word_b | input | 1 | Valid word completed on bus B |
| pkt_open | input | 1 | A recording packet is open |
| gap_limit | input | 16 | Gap limit N in 10 µs units; 0 disables |
| ien_ready | input | 1 | Enable for the packet-ready flag |
| ien_gap | input | 1 | Enable for the gap-expired flag |
| clr_ready | input | 1 | Write-one-to-clear pulse for `irq_ready` |
| clr_gap | input | 1 | Write-one-to-clear pulse for `irq_gap` |
| finalize | output | 1 | One-cycle packet finalize pulse |
| irq_ready | output | 1 | Sticky packet-ready flag |
| irq_gap | output | 1 | Sticky gap-expired flag |

## Verification
A vector table exercises several limits, including 1, 2, 3, 5 and 20. For each limit the bench applies exactly 10N+3 strobes, which must finalize, and exactly 10N+2 strobes, which must not; this pins the unit count and the 3 µs tail to the exact strobe. Restart tests place a second word on the other bus partway through a gap, and one test places a word on the very strobe that would finalize. These tell a restart on either bus apart from a restart on only one bus, and they show which wins at the boundary. Runs with the mode cleared, with the packet closed and with a zero limit must produce no pulse. Runs with each interrupt enable on or off, followed by clear pulses, show that each flag is set and cleared on its own.

// File: rtl/bgw_pkg.sv
package bgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_GRACE = 2'd2
  } bgw_state_e;
endpackage

// File: rtl/bgw_divider.sv
module bgw_divider #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic unit_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign unit_tick = en && !clr && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)            cnt_d = '0;
    else if (unit_tick) cnt_d = '0;
    else if (en)        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_div_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/bgw_fsm.sv
module bgw_fsm
  import bgw_pkg::*;
#(
  parameter int LIMIT_W = 16,
  parameter int LAG     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_pkt,
  input  logic               strobe,
  input  logic               unit_tick,
  input  logic               word_any,
  input  logic               pkt_open,
  input  logic [LIMIT_W-1:0] limit,
  output logic               counting,
  output logic               fin
);
  localparam int GW = (LAG > 1) ? $clog2(LAG) : 1;
  localparam logic [GW-1:0] GLAST = GW'(LAG - 1);

  bgw_state_e         st_q, st_d;
  logic [LIMIT_W-1:0] units_q, units_d;
  logic [GW-1:0]      grc_q, grc_d;
  logic               fin_q, fin_d;
  logic [LIMIT_W:0]   units_inc;

  assign units_inc = {1'b0, units_q} + 1'b1;
  assign counting  = (st_q == ST_COUNT);
  assign fin       = fin_q;

  always_comb begin
    st_d    = st_q;
    units_d = units_q;
    grc_d   = grc_q;
    fin_d   = 1'b0;
    if (!mode_pkt || (limit == '0)) begin
      st_d = ST_IDLE;
    end else if (word_any) begin
      st_d    = ST_COUNT;
      units_d = '0;
      grc_d   = '0;
    end else begin
      unique case (st_q)
        ST_COUNT: begin
          if (!pkt_open) begin
            st_d = ST_IDLE;
          end else if (units_q >= limit) begin
            st_d  = ST_GRACE;
            grc_d = '0;
          end else if (unit_tick) begin
            if (units_inc >= {1'b0, limit}) begin
              st_d  = ST_GRACE;
              grc_d = '0;
            end else begin
              units_d = units_inc[LIMIT_W-1:0];
            end
          end
        end
        ST_GRACE: begin
          if (!pkt_open) begin
            st_d = ST_IDLE;
          end else if (strobe) begin
            if (grc_q == GLAST) begin
              fin_d = 1'b1;
              st_d  = ST_IDLE;
            end else begin
              grc_d = grc_q + 1'b1;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      units_q <= '0;
      grc_q   <= '0;
      fin_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      units_q <= units_d;
      grc_q   <= grc_d;
      fin_q   <= fin_d;
    end
  end

  assert_fin_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);
  assert_zero_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |=> !fin_q);
  assert_mode_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_pkt |=> !fin_q);
  assert_closed_pkt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_open |=> !fin_q);
  assert_idle_after_fin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (st_q == ST_IDLE));
  assert_word_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word_any |=> !fin_q);
endmodule

// File: rtl/bgw_flag.sv
module bgw_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag_q);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);
endmodule

// File: rtl/bus_gap_watchdog.sv
module bus_gap_watchdog #(
  parameter int LIMIT_W   = 16,
  parameter int UNIT_DIV  = 10,
  parameter int VALID_LAG = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_pkt,
  input  logic               tick_1us,
  input  logic               word_a,
  input  logic               word_b,
  input  logic               pkt_open,
  input  logic [LIMIT_W-1:0] gap_limit,
  input  logic               ien_ready,
  input  logic               ien_gap,
  input  logic               clr_ready,
  input  logic               clr_gap,
  output logic               finalize,
  output logic               irq_ready,
  output logic               irq_gap
);
  localparam int N_IRQ = 2;

  logic             word_any;
  logic             unit_tick;
  logic             counting;
  logic             fin;
  logic [N_IRQ-1:0] irq_en, irq_clr, irq_set, irq_q;

  assign word_any = word_a | word_b;

  bgw_divider #(.DIV(UNIT_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (word_any | !counting),
    .en        (tick_1us & counting),
    .unit_tick (unit_tick)
  );

  bgw_fsm #(.LIMIT_W(LIMIT_W), .LAG(VALID_LAG)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_pkt  (mode_pkt),
    .strobe    (tick_1us),
    .unit_tick (unit_tick),
    .word_any  (word_any),
    .pkt_open  (pkt_open),
    .limit     (gap_limit),
    .counting  (counting),
    .fin       (fin)
  );

  assign irq_en  = {ien_gap, ien_ready};
  assign irq_clr = {clr_gap, clr_ready};

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    assign irq_set[i] = fin & irq_en[i];
    bgw_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (irq_set[i]),
      .clr   (irq_clr[i]),
      .flag  (irq_q[i])
    );
  end

  assign finalize  = fin;
  assign irq_ready = irq_q[0];
  assign irq_gap   = irq_q[1];

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_ready) || $rose(irq_gap)) |-> $past(finalize));
endmodule

// File: tb/bus_gap_watchdog_bench.sv
module bus_gap_watchdog_bench;
  logic        clk;
  logic        rst_n;
  logic        mode_pkt, tick_1us, word_a, word_b, pkt_open;
  logic [15:0] gap_limit;
  logic        ien_ready, ien_gap, clr_ready, clr_gap;
  logic        finalize, irq_ready, irq_gap;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit seen;

  bus_gap_watchdog u_bus_gap_watchdog (
    .clk(clk), .rst_n(rst_n), .mode_pkt(mode_pkt), .tick_1us(tick_1us),
    .word_a(word_a), .word_b(word_b), .pkt_open(pkt_open),
    .gap_limit(gap_limit), .ien_ready(ien_ready), .ien_gap(ien_gap),
    .clr_ready(clr_ready), .clr_gap(clr_gap), .finalize(finalize),
    .irq_ready(irq_ready), .irq_gap(irq_gap)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam int NV = 8;
  localparam int V_LIM [NV] = '{1, 1, 2, 20, 20, 5, 0, 3};
  localparam int V_STB [NV] = '{13, 12, 23, 203, 202, 53, 40, 33};
  localparam int V_FIN [NV] = '{1, 0, 1, 1, 0, 1, 0, 1};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  task automatic pulse_word(input bit bus_b);
    @(negedge clk);
    if (bus_b) word_b = 1'b1; else word_a = 1'b1;
    @(negedge clk);
    word_a = 1'b0;
    word_b = 1'b0;
  endtask

  // applies n strobes; sets seen if finalize is observed after any of them
  task automatic strobes(input int n);
    seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_1us = 1'b1;
      @(negedge clk);
      tick_1us = 1'b0;
      if (finalize) seen = 1'b1;
    end
  endtask

  initial begin
    rst_n = 1'b0; mode_pkt = 1'b1; tick_1us = 1'b0; word_a = 1'b0; word_b = 1'b0;
    pkt_open = 1'b1; gap_limit = 16'd0; ien_ready = 1'b1; ien_gap = 1'b1;
    clr_ready = 1'b0; clr_gap = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!finalize && !irq_ready && !irq_gap, "R10 reset outputs", {finalize, irq_ready, irq_gap}, 0);
    rst_n = 1'b1;

    // R1 / R3: vector table of limits and strobe counts
    for (int v = 0; v < NV; v++) begin
      gap_limit = 16'(V_LIM[v]);
      pulse_word(v[0]);
      strobes(V_STB[v] - 1);
      check(!seen, "R1 no early finalize", seen, 0);
      strobes(1);
      check(seen == V_FIN[v][0], (V_LIM[v] == 0) ? "R3 zero limit" : "R1 finalize timing", seen, V_FIN[v]);
      if (V_FIN[v] != 0) begin
        @(negedge clk);
        check(!finalize, "R1 single-cycle pulse", finalize, 0);
      end
    end

    // R7: both flags set by the last finalizing vector
    check(irq_ready && irq_gap, "R7 flags set", {irq_ready, irq_gap}, 3);
    repeat (5) @(negedge clk);
    check(irq_ready && irq_gap, "R7 flags sticky", {irq_ready, irq_gap}, 3);

    // R8: clear one flag only
    clr_ready = 1'b1;
    @(negedge clk);
    clr_ready = 1'b0;
    check(!irq_ready && irq_gap, "R8 clear ready only", {irq_ready, irq_gap}, 1);
    clr_gap = 1'b1;
    @(negedge clk);
    clr_gap = 1'b0;
    check(!irq_gap, "R8 clear gap", irq_gap, 0);

    // R7: disabled enable leaves flag alone
    gap_limit = 16'd1; ien_ready = 1'b0;
    pulse_word(1'b0);
    strobes(13);
    check(seen, "R7 finalize with ready disabled", seen, 1);
    @(negedge clk);
    check(!irq_ready && irq_gap, "R7 enable gating", {irq_ready, irq_gap}, 1);
    ien_ready = 1'b1;

    // R6: idle after finalize
    strobes(40);
    check(!seen, "R6 no second finalize", seen, 0);

    // R2: word on the other bus restarts
    gap_limit = 16'd2;
    pulse_word(1'b0);
    strobes(15);
    pulse_word(1'b1);
    strobes(22);
    check(!seen, "R2 restart from bus B", seen, 0);
    strobes(1);
    check(seen, "R2 finalize after restart", seen, 1);

    // R9: word on the final strobe wins
    gap_limit = 16'd1;
    pulse_word(1'b1);
    strobes(12);
    @(negedge clk);
    tick_1us = 1'b1; word_a = 1'b1;
    @(negedge clk);
    tick_1us = 1'b0; word_a = 1'b0;
    check(!finalize, "R9 word beats final strobe", finalize, 0);
    strobes(12);
    check(!seen, "R9 restarted count early", seen, 0);
    strobes(1);
    check(seen, "R9 restarted count finalizes", seen, 1);

    // R4: mode off
    mode_pkt = 1'b0;
    pulse_word(1'b0);
    strobes(30);
    check(!seen, "R4 mode off", seen, 0);
    mode_pkt = 1'b1;

    // R5: packet closed
    pulse_word(1'b0);
    pkt_open = 1'b0;
    strobes(30);
    check(!seen, "R5 packet closed", seen, 0);
    pkt_open = 1'b1;
    strobes(30);
    check(!seen, "R5 dropped measurement stays idle", seen, 0);

    // R8: set wins over clear in the same cycle
    clr_ready = 1'b1;
    @(negedge clk);
    clr_ready = 1'b0;
    pulse_word(1'b0);
    strobes(12);
    @(negedge clk);
    tick_1us = 1'b1;
    @(negedge clk);
    tick_1us = 1'b0;
    check(finalize, "R1 finalize before set/clear", finalize, 1);
    clr_ready = 1'b1;
    @(negedge clk);
    clr_ready = 1'b0;
    check(irq_ready, "R8 set beats clear", irq_ready, 1);

    summary();
  end
endmodule